// File: doc/BRIEF.md
# Single-Clock Queue with Selectable Read Timing

This block is a first-in first-out queue for one clock domain. A producer offers a word with a push strobe, and the word is taken on any edge where the queue signals room. A consumer takes the oldest word with a pop strobe on any edge where the queue signals that it holds data. A fill output reports the number of words held at every cycle.

A build-time parameter sets when read data becomes visible. In fall-through mode the oldest stored word is already on the read data port whenever the queue is non-empty, so the consumer sees it before asking for it. In standard mode the read data port is a register: it loads the oldest word on the edge that accepts a pop and shows it from the next cycle until the next accepted pop.

Any capacity works, including values that are not powers of two (the default is 5) and zero. The pointers wrap at exactly the capacity, with no rounding up. A capacity of zero gives a queue that never takes a write and never offers data.

Top module: `sync_queue`

## Requirements
- R1: `rd_ready` is 1 exactly when `fill` is greater than zero.
- R2: `wr_ready` is 1 exactly when `fill` is less than `DEPTH`.
- R3: On each edge `fill` goes up by one for an accepted push alone, down by one for an accepted pop alone, and keeps its value when both are accepted together or neither is.
- R4: While `rst` is 1 at an edge, the queue empties: after that edge `fill` is 0, `rd_ready` is 0, `wr_ready` is 1 (for `DEPTH` > 0), and in standard mode `rd_data` is 0.
- R5: In fall-through mode (`RD_MODE` = `RD_FALLTHRU`, encoded 1), whenever `rd_ready` is 1, `rd_data` already holds the oldest stored word, with no pop needed.
- R6: In standard mode (`RD_MODE` = `RD_STANDARD`, encoded 0), `rd_data` loads the oldest word on the edge that accepts a pop and keeps its value across every edge that does not accept a pop.
- R7: Words come out in the order they were accepted, including when the pointers wrap past the last slot of a capacity that is not a power of two.
- R8: A push while `wr_ready` is 0 is ignored: `fill` does not change, and the words already stored come out later unchanged and in order.
- R9: A pop while `rd_ready` is 0 is ignored: `fill` stays 0 and later pushed words read out correctly.
- R10: `fill` is `$clog2(DEPTH+1)` bits wide, reaches `DEPTH` when full, and never goes above `DEPTH`.
- R11: With `DEPTH` = 0, `wr_ready`, `rd_ready` and `fill` stay 0 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_push | input | 1 | Producer requests a write this cycle |
| wr_ready | output | 1 | Queue has room; a push is taken on this edge |
| rd_data | output | DATA_W | Oldest word (fall-through) or last popped word (standard) |
| rd_pop | input | 1 | Consumer requests a read this cycle |
| rd_ready | output | 1 | Queue holds data; a pop is taken on this edge |
| fill | output | LW | Number of words held, from 0 to DEPTH |

## Verification
A wrong occupancy count shows on the ports in the cycle after the edge where it goes wrong: `fill` has the wrong value, and one of the two ready flags flips too early or too late at the empty and full limits. A pointer that skips or wraps at the wrong slot does not change `fill`. It shows up only when the affected word reaches the head, as a word out of order or a stale word on `rd_data`. So the stimulus runs the pointers past the wrap point of a depth of 5 and compares every word that comes out. In standard mode, a register that loads on the wrong edge shows up one cycle later as `rd_data` changing without an accepted pop.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
    } accept_t;

    function automatic int ptr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int fill_bits(input int depth);
        return (depth < 1) ? 1 : $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/sq_wrap_ptr.sv
module sq_wrap_ptr #(
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/sq_occupancy.sv
module sq_occupancy
    import sq_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  accept_t       acc,
    output logic [LW-1:0] fill,
    output logic          not_empty,
    output logic          not_full
);
    localparam logic [LW-1:0] CAP = LW'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else begin
            unique case ({acc.push, acc.pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign not_empty = (fill != '0);
    assign not_full  = (fill < CAP);
endmodule

// File: rtl/sq_store.sv
module sq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 5,
    parameter int PW     = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/sq_read_stage.sv
module sq_read_stage
    import sq_pkg::*;
#(
    parameter int       DATA_W = 8,
    parameter rd_mode_e MODE   = RD_FALLTHRU
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] head,
    output logic [DATA_W-1:0] rd_data
);
    generate
        if (MODE == RD_FALLTHRU) begin : g_fallthru
            logic unused_ft;
            assign unused_ft = ^{clk, rst, take};
            assign rd_data   = head;
        end else begin : g_standard
            always_ff @(posedge clk) begin
                if (rst) begin
                    rd_data <= '0;
                end else if (take) begin
                    rd_data <= head;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sync_queue.sv
module sync_queue
    import sq_pkg::*;
#(
    parameter int       DATA_W  = 8,
    parameter int       DEPTH   = 5,
    parameter rd_mode_e RD_MODE = RD_FALLTHRU,
    localparam int      PW      = ptr_bits(DEPTH),
    localparam int      LW      = fill_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_push,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_pop,
    output logic              rd_ready,
    output logic [LW-1:0]     fill
);
    generate
        if (DEPTH == 0) begin : g_empty
            logic unused_in;
            assign unused_in = ^{clk, rst, wr_data, wr_push, rd_pop};
            assign wr_ready  = 1'b0;
            assign rd_ready  = 1'b0;
            assign fill      = '0;
            assign rd_data   = '0;
        end else begin : g_queue
            accept_t           acc;
            logic [PW-1:0]     wptr;
            logic [PW-1:0]     rptr;
            logic [DATA_W-1:0] head;

            assign acc.push = wr_push & wr_ready;
            assign acc.pop  = rd_pop & rd_ready;

            sq_occupancy #(.DEPTH(DEPTH), .LW(LW)) u_occ (
                .clk       (clk),
                .rst       (rst),
                .acc       (acc),
                .fill      (fill),
                .not_empty (rd_ready),
                .not_full  (wr_ready)
            );

            sq_wrap_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
                .clk (clk),
                .rst (rst),
                .adv (acc.push),
                .ptr (wptr)
            );

            sq_wrap_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
                .clk (clk),
                .rst (rst),
                .adv (acc.pop),
                .ptr (rptr)
            );

            sq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_store (
                .clk   (clk),
                .we    (acc.push),
                .waddr (wptr),
                .wdata (wr_data),
                .raddr (rptr),
                .rdata (head)
            );

            sq_read_stage #(.DATA_W(DATA_W), .MODE(RD_MODE)) u_rd (
                .clk     (clk),
                .rst     (rst),
                .take    (acc.pop),
                .head    (head),
                .rd_data (rd_data)
            );
        end
    endgenerate
endmodule

// File: rtl/sync_queue_chk.sv
module sync_queue_chk
    import sq_pkg::*;
#(
    parameter int       DATA_W  = 8,
    parameter int       DEPTH   = 5,
    parameter rd_mode_e RD_MODE = RD_FALLTHRU,
    parameter int       LW      = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_push,
    input logic              wr_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_pop,
    input logic              rd_ready,
    input logic [LW-1:0]     fill
);
    logic push_ok;
    logic pop_ok;
    assign push_ok = wr_push && wr_ready;
    assign pop_ok  = rd_pop && rd_ready;

    AST_RD_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rd_ready == (fill != '0)); // R1
    AST_WR_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        wr_ready == (fill < LW'(DEPTH))); // R2
    AST_FILL_UP: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !pop_ok) |=> fill == $past(fill) + 1'b1); // R3
    AST_FILL_DOWN: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !push_ok) |=> fill == $past(fill) - 1'b1); // R3
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push_ok == pop_ok) |=> $stable(fill)); // R3
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (fill == '0 && !rd_ready)); // R4
    AST_FILL_MAX: assert property (@(posedge clk) disable iff (rst)
        fill <= LW'(DEPTH)); // R10

    generate
        if (RD_MODE == RD_STANDARD) begin : g_std
            AST_STD_HOLD: assert property (@(posedge clk) disable iff (rst)
                !pop_ok |=> $stable(rd_data)); // R6
        end
        if (DEPTH == 0) begin : g_zero
            AST_ZERO_CLOSED: assert property (@(posedge clk)
                !wr_ready && !rd_ready && fill == '0); // R11
        end
    endgenerate
endmodule

bind sync_queue sync_queue_chk #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .RD_MODE (RD_MODE),
    .LW      (LW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_push  (wr_push),
    .wr_ready (wr_ready),
    .rd_data  (rd_data),
    .rd_pop   (rd_pop),
    .rd_ready (rd_ready),
    .fill     (fill)
);

// File: tb/sync_queue_bench.sv
`timescale 1ns/1ps
module sync_queue_bench;
    import sq_pkg::*;

    localparam int CAP = 5;
    localparam int NV  = 21;
    // each vector: {push, pop, data}
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'hA1},
        {1'b1, 1'b0, 8'hA2},
        {1'b1, 1'b1, 8'hA3},
        {1'b1, 1'b0, 8'hA4},
        {1'b1, 1'b0, 8'hA5},
        {1'b1, 1'b0, 8'hA6},
        {1'b1, 1'b0, 8'hA7},
        {1'b1, 1'b1, 8'hA8},
        {1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'hB0},
        {1'b1, 1'b0, 8'hB1},
        {1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'hC0},
        {1'b1, 1'b1, 8'hC1},
        {1'b0, 1'b1, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wr_data = '0;
    logic       wr_push = 1'b0;
    logic       rd_pop  = 1'b0;

    logic       ft_wr_ready, ft_rd_ready, sd_wr_ready, sd_rd_ready, z_wr_ready, z_rd_ready;
    logic [7:0] ft_rd_data, sd_rd_data, z_rd_data;
    logic [2:0] ft_fill, sd_fill;
    logic       z_fill;

    int checks = 0;
    int errors = 0;
    logic [7:0] mq[$];
    logic [7:0] std_exp = '0;

    always #2 clk = ~clk;

    sync_queue #(.DATA_W(8), .DEPTH(CAP), .RD_MODE(RD_FALLTHRU)) u_sync_queue (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_push(wr_push), .wr_ready(ft_wr_ready),
        .rd_data(ft_rd_data), .rd_pop(rd_pop), .rd_ready(ft_rd_ready), .fill(ft_fill));

    sync_queue #(.DATA_W(8), .DEPTH(CAP), .RD_MODE(RD_STANDARD)) u_sync_queue_std (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_push(wr_push), .wr_ready(sd_wr_ready),
        .rd_data(sd_rd_data), .rd_pop(rd_pop), .rd_ready(sd_rd_ready), .fill(sd_fill));

    sync_queue #(.DATA_W(8), .DEPTH(0), .RD_MODE(RD_FALLTHRU)) u_sync_queue_zero (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_push(wr_push), .wr_ready(z_wr_ready),
        .rd_data(z_rd_data), .rd_pop(rd_pop), .rd_ready(z_rd_ready), .fill(z_fill));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // pre-edge checks of both 5-deep queues and the zero-depth one
    task automatic check_state(input string ftag);
        chk("R1 rd_ready", 32'(ft_rd_ready), 32'(mq.size() > 0));
        chk("R1 rd_ready std", 32'(sd_rd_ready), 32'(mq.size() > 0));
        chk("R2 wr_ready", 32'(ft_wr_ready), 32'(mq.size() < CAP));
        chk(ftag, 32'(ft_fill), 32'(mq.size()));
        chk(ftag, 32'(sd_fill), 32'(mq.size()));
        if (mq.size() > 0) chk("R7 fall-through head order", 32'(ft_rd_data), 32'(mq[0]));
        chk("R6 standard data", 32'(sd_rd_data), 32'(std_exp));
        chk("R11 zero-depth", 32'({z_wr_ready, z_rd_ready, z_fill}), 32'(0));
    endtask

    task automatic step(input logic p, input logic q, input logic [7:0] d, input string ftag);
        logic pa, qa;
        @(negedge clk);
        wr_push = p;
        rd_pop  = q;
        wr_data = d;
        #0.5;
        check_state(ftag);
        pa = p && (mq.size() < CAP);
        qa = q && (mq.size() > 0);
        @(posedge clk);
        if (qa) begin
            std_exp = mq[0];
            void'(mq.pop_front());
        end
        if (pa) mq.push_back(d);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R4: state straight after reset
        chk("R4 fill after reset", 32'(ft_fill), 32'(0));
        chk("R4 rd_ready after reset", 32'(ft_rd_ready), 32'(0));
        chk("R4 wr_ready after reset", 32'(ft_wr_ready), 32'(1));
        chk("R4 std data after reset", 32'(sd_rd_data), 32'(0));

        for (int i = 0; i < NV; i++) begin
            string t;
            t = "R3 fill";
            if (i == 8) t = "R8 push while full ignored";
            if (i == 7) t = "R10 fill reaches depth";
            if (i == 1 || i == 18) t = "R9 pop while empty ignored";
            step(VEC[i][9], VEC[i][8], VEC[i][7:0], t);
        end

        // R5: fall-through head visible before any pop is requested
        step(1'b1, 1'b0, 8'h5A, "R3 fill");
        step(1'b1, 1'b0, 8'h6B, "R3 fill");
        @(negedge clk);
        wr_push = 1'b0;
        rd_pop  = 1'b0;
        #0.5;
        chk("R5 head shown without pop", 32'(ft_rd_data), 32'(8'h5A));
        chk("R6 std data unchanged without pop", 32'(sd_rd_data), 32'(std_exp));
        step(1'b0, 1'b1, 8'h00, "R3 fill");
        @(negedge clk);
        rd_pop = 1'b0;
        #0.5;
        chk("R6 std data loaded by pop", 32'(sd_rd_data), 32'(8'h5A));
        chk("R5 next head shown", 32'(ft_rd_data), 32'(8'h6B));

        // R4: reset while holding data
        step(1'b1, 1'b0, 8'h77, "R3 fill");
        @(negedge clk);
        wr_push = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mq.delete();
        std_exp = '0;
        #0.5;
        chk("R4 fill cleared", 32'(ft_fill), 32'(0));
        chk("R4 rd_ready cleared", 32'(ft_rd_ready), 32'(0));
        chk("R4 wr_ready set", 32'(sd_wr_ready), 32'(1));
        chk("R4 std data cleared", 32'(sd_rd_data), 32'(0));
        step(1'b1, 1'b0, 8'h3C, "R4 fill after reset");
        step(1'b0, 1'b0, 8'h00, "R3 fill");
        chk("R5 head after reset", 32'(ft_rd_data), 32'(8'h3C));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule